// File: doc/BRIEF.md
# Programmable LED Blink Generator

This block makes the blink pattern for status LEDs on general-purpose output pins. It has two independent channels. Each channel holds a rate code, a control field and a pin map, and software sets them through a small write/read register port. A divided-down slow tick paces all timing, and each channel counts its period in ticks. A mode input picks one of two code tables. In the narrow table only the two low code bits count, and every rate runs at 50% duty. In the wide table a sparse 5-bit code sets both the rate and the duty cycle.

Per channel, the control field can turn the waveform into one short pulse per period and can make the LED active-low. In wide mode it can also arm a long-press clear. The block synchronises an active-low panel switch input. When that switch stays low for longer than a set number of seconds, the block empties the pin map of every armed channel, and that LED goes dark.

Top module: `blink_led_gen`

## Requirements
- R1: Registers are decoded as addr[2] = channel and addr[1:0] = 0 rate code (5 bits), 1 control (3 bits), 2 pin map (MAP_W bits). A read returns the field zero-extended, and addr[1:0] = 3 reads 0. A write to one channel leaves the other channel's fields unchanged.
- R2: A tick is raised once every CLK_PER_TICK clocks, counting from reset release. Each channel's period counter steps only on a tick and wraps to 0 when it reaches the period length.
- R3: In narrow mode (ext_mode_i = 0) only code bits [1:0] count. 0, 1, 2 and 3 give periods of 1/4, 1, 4 and 8 seconds, with the LED active for the first half of each period.
- R4: In wide mode, codes 0, 1, 2 and 3 give periods of 1/4, 1, 4 and 1/2 seconds at 50% duty.
- R5: In wide mode, codes 4 and 5 give a 4 s period with the LED active for the first quarter or first three quarters. Codes 6 and 7 do the same on an 8 s period.
- R6: In wide mode, code 8 gives a 2.5 s period at 20% duty, code 16 a 2 s period at 50%, and code 24 an 8 s period at 50%. Any other code keeps the output idle while the counter runs on a 1 s period.
- R7: Control bit 0 (short pulse) makes the LED active only while the period counter is 0, which is one tick per period.
- R8: Control bit 1 clear means active drives 1 and idle drives 0. Set, it means active drives 0 and idle drives 1.
- R9: A pin map value m from 1 to NUM_PINS routes the channel to led_o[m-1]. A value of 0 or larger than NUM_PINS routes it nowhere. Channel 0 wins a shared pin, and pins with no channel drive 0.
- R10: The switch passes through two flops. After it has been seen low on more than PRESS_SEC*TICK_HZ ticks in a row, the block clears the pin map of every channel whose control bit 2 is set, but only in wide mode. It clears once per press. The switch going high restarts the count, and a register write in the same cycle as a clear takes priority.
- R11: Writing a channel's rate code sets that channel's period counter to 0, so the new waveform begins at the start of its period.
- R12: After reset, all registers are 0 and every pin drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | 1 selects the wide 5-bit code table |
| panel_sw_ni | input | 1 | Active-low panel switch, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 5 | Write data |
| rdata_o | output | 5 | Read data for addr_i |
| led_o | output | NUM_PINS | LED pin levels |

## Verification
The hardest case to reach is the long-press clear at its exact boundary. It needs the switch held low across dozens of ticks, seen through the synchroniser, and on a channel that is both armed and in wide mode. The bench runs a small configuration (four clocks per tick, eight ticks per second) so that a press fits in a few hundred cycles. It compares the pin map read-back on every cycle with a reference that counts ticks. It repeats the press while the switch is released early, while the channel is not armed, and while narrow mode is selected.

// File: rtl/blink_pkg.sv
package blink_pkg;
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CODE_W = 5;
    localparam int unsigned CTRL_W = 3;
    localparam int unsigned SHP_W  = 20;

    localparam int unsigned CTL_SHORT  = 0;
    localparam int unsigned CTL_LOWACT = 1;
    localparam int unsigned CTL_PCLR   = 2;

    typedef struct packed {
        logic             ok;
        logic [SHP_W-1:0] period;
        logic [SHP_W-1:0] high;
    } shape_t;

    // period and active span in ticks, hz = ticks per second
    function automatic shape_t shape_of(input logic ext, input logic [CODE_W-1:0] code,
                                        input int unsigned hz);
        shape_t s;
        int unsigned p;
        int unsigned h;
        s.ok = 1'b1;
        p = hz;
        h = hz / 2;
        if (!ext) begin
            case (code[1:0])
                2'd0:    p = hz / 4;
                2'd1:    p = hz;
                2'd2:    p = hz * 4;
                default: p = hz * 8;
            endcase
            h = p / 2;
        end else begin
            case (code)
                5'd0:    begin p = hz / 4;     h = p / 2;     end
                5'd1:    begin p = hz;         h = p / 2;     end
                5'd2:    begin p = hz * 4;     h = p / 2;     end
                5'd3:    begin p = hz / 2;     h = p / 2;     end
                5'd4:    begin p = hz * 4;     h = hz;        end
                5'd5:    begin p = hz * 4;     h = hz * 3;    end
                5'd6:    begin p = hz * 8;     h = hz * 2;    end
                5'd7:    begin p = hz * 8;     h = hz * 6;    end
                5'd8:    begin p = hz * 5 / 2; h = hz / 2;    end
                5'd16:   begin p = hz * 2;     h = hz;        end
                5'd24:   begin p = hz * 8;     h = hz * 4;    end
                default: begin s.ok = 1'b0; p = hz; h = 0;    end
            endcase
        end
        s.period = SHP_W'(p);
        s.high   = SHP_W'(h);
        return s;
    endfunction
endpackage

// File: rtl/blink_press.sv
module blink_press import blink_pkg::*; #(
    parameter int unsigned TICK_HZ   = 32,
    parameter int unsigned PRESS_SEC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic sw_ni,
    output logic fire_o
);
    localparam int unsigned LONG = PRESS_SEC * TICK_HZ;
    localparam int unsigned PC_W = $clog2(LONG + 2);

    typedef struct packed {
        logic [1:0]      sync;
        logic [PC_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic low;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], sw_ni};
        low      = !s_q.sync[1];
        if (!low)
            s_d.cnt = '0;
        else if (tick_i && (s_q.cnt != PC_W'(LONG + 1)))
            s_d.cnt = s_q.cnt + PC_W'(1);
        fire_o = low && tick_i && (s_q.cnt == PC_W'(LONG));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.sync <= 2'b11;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    p_single_fire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |=> !fire_o);
    p_release_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.sync[1] |=> (s_q.cnt == '0));
endmodule

// File: rtl/blink_regs.sv
module blink_regs import blink_pkg::*; #(
    parameter int unsigned MAP_W = 3
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [2:0]                     addr_i,
    input  logic [CODE_W-1:0]              wdata_i,
    input  logic [NUM_CH-1:0]              clr_i,
    output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
    output logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_o,
    output logic [NUM_CH-1:0][MAP_W-1:0]   map_o,
    output logic [NUM_CH-1:0]              restart_o,
    output logic [CODE_W-1:0]              rdata_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] code;
        logic [NUM_CH-1:0][CTRL_W-1:0] ctrl;
        logic [NUM_CH-1:0][MAP_W-1:0]  map;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            restart_o[ch] = 1'b0;
            if (clr_i[ch])
                s_d.map[ch] = '0;
            if (wr_en_i && (addr_i[2] == 1'(ch))) begin
                case (addr_i[1:0])
                    2'd0: begin
                        s_d.code[ch]  = wdata_i;
                        restart_o[ch] = 1'b1;
                    end
                    2'd1:    s_d.ctrl[ch] = wdata_i[CTRL_W-1:0];
                    2'd2:    s_d.map[ch]  = wdata_i[MAP_W-1:0];
                    default: ;
                endcase
            end
        end
        case (addr_i[1:0])
            2'd0:    rdata_o = s_q.code[addr_i[2]];
            2'd1:    rdata_o = CODE_W'(s_q.ctrl[addr_i[2]]);
            2'd2:    rdata_o = CODE_W'(s_q.map[addr_i[2]]);
            default: rdata_o = '0;
        endcase
        code_o = s_q.code;
        ctrl_o = s_q.ctrl;
        map_o  = s_q.map;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_clear_map_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i[g] && !(wr_en_i && (addr_i == {1'(g), 2'd2})) |=> (s_q.map[g] == '0));
        p_other_ch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_en_i && (addr_i[2] != 1'(g)) && !clr_i[g]
            |=> $stable(s_q.code[g]) && $stable(s_q.ctrl[g]) && $stable(s_q.map[g]));
    end
endmodule

// File: rtl/blink_wave.sv
module blink_wave import blink_pkg::*; #(
    parameter int unsigned TICK_HZ = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic              ext_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              lvl_o
);
    localparam int unsigned CNT_W = $clog2(8 * TICK_HZ + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t    s_d, s_q;
    shape_t shp;
    logic   on;

    always_comb begin
        shp = shape_of(ext_i, code_i, TICK_HZ);
        s_d = s_q;
        if (restart_i)
            s_d.cnt = '0;
        else if (tick_i) begin
            if ((SHP_W'(s_q.cnt) + SHP_W'(1)) >= shp.period)
                s_d.cnt = '0;
            else
                s_d.cnt = s_q.cnt + CNT_W'(1);
        end
        on = shp.ok && (ctrl_i[CTL_SHORT] ? (s_q.cnt == '0) : (SHP_W'(s_q.cnt) < shp.high));
        lvl_o = on ? !ctrl_i[CTL_LOWACT] : ctrl_i[CTL_LOWACT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    p_restart_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (s_q.cnt == '0));
    p_hold_between_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i && !restart_i |=> $stable(s_q.cnt));
endmodule

// File: rtl/blink_led_gen.sv
module blink_led_gen import blink_pkg::*; #(
    parameter int unsigned CLK_PER_TICK = 1000000,
    parameter int unsigned TICK_HZ      = 32,
    parameter int unsigned PRESS_SEC    = 4,
    parameter int unsigned NUM_PINS     = 4,
    parameter int unsigned MAP_W        = 3
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ext_mode_i,
    input  logic                panel_sw_ni,
    input  logic                wr_en_i,
    input  logic [2:0]          addr_i,
    input  logic [CODE_W-1:0]   wdata_i,
    output logic [CODE_W-1:0]   rdata_o,
    output logic [NUM_PINS-1:0] led_o
);
    localparam int unsigned DIV_W = $clog2(CLK_PER_TICK);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } st_t;

    st_t  s_d, s_q;
    logic tick;
    logic fire;

    logic [NUM_CH-1:0][CODE_W-1:0] code;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl;
    logic [NUM_CH-1:0][MAP_W-1:0]  map;
    logic [NUM_CH-1:0]             restart;
    logic [NUM_CH-1:0]             clr;
    logic [NUM_CH-1:0]             lvl;

    always_comb begin
        tick  = (s_q.div == DIV_W'(CLK_PER_TICK - 1));
        s_d.div = tick ? '0 : s_q.div + DIV_W'(1);
        for (int ch = 0; ch < NUM_CH; ch++)
            clr[ch] = fire && ext_mode_i && ctrl[ch][CTL_PCLR];
        led_o = '0;
        for (int ch = NUM_CH - 1; ch >= 0; ch--)
            for (int p = 0; p < NUM_PINS; p++)
                if (map[ch] == MAP_W'(p + 1))
                    led_o[p] = lvl[ch];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    blink_press #(.TICK_HZ(TICK_HZ), .PRESS_SEC(PRESS_SEC)) u_press (
        .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .sw_ni(panel_sw_ni), .fire_o(fire)
    );

    blink_regs #(.MAP_W(MAP_W)) u_regs (
        .clk_i    (clk_i),   .rst_ni (rst_ni),  .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i  (wdata_i), .clr_i  (clr),     .code_o (code),    .ctrl_o(ctrl),
        .map_o    (map),     .restart_o(restart), .rdata_o(rdata_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        blink_wave #(.TICK_HZ(TICK_HZ)) u_wave (
            .clk_i (clk_i),   .rst_ni   (rst_ni),     .tick_i(tick), .restart_i(restart[g]),
            .ext_i (ext_mode_i), .code_i(code[g]),    .ctrl_i(ctrl[g]), .lvl_o(lvl[g])
        );
    end

    p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick |=> !tick);
    p_clear_needs_wide_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr != '0) |-> ext_mode_i);
endmodule

// File: tb/blink_led_gen_tb.sv
module blink_led_gen_tb;
    localparam int CPT  = 4;
    localparam int HZ   = 8;
    localparam int PSEC = 4;
    localparam int NP   = 4;
    localparam int MW   = 3;
    localparam int LONG = PSEC * HZ;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext = 1'b0;
    logic          sw_n = 1'b1;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [4:0]    wdata = '0;
    logic [4:0]    rdata;
    logic [NP-1:0] led;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R12";
    logic [2:0] obs = '0;

    blink_led_gen #(.CLK_PER_TICK(CPT), .TICK_HZ(HZ), .PRESS_SEC(PSEC),
                    .NUM_PINS(NP), .MAP_W(MW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext), .panel_sw_ni(sw_n),
        .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .led_o(led)
    );

    always #5 clk = ~clk;

    // reference state, built from the requirements
    int         mdiv;
    int         mcnt [2];
    logic [4:0] mcode [2];
    logic [2:0] mctrl [2];
    logic [MW-1:0] mmap [2];
    logic [1:0] msync;
    int         mpc;
    bit         tk, fire, sok;
    int         sp, sh;

    function automatic void shape(input logic e, input logic [4:0] c,
                                  output bit ok, output int p, output int h);
        ok = 1'b1;
        if (!e) begin
            case (c[1:0])
                2'd0: p = HZ / 4;
                2'd1: p = HZ;
                2'd2: p = 4 * HZ;
                default: p = 8 * HZ;
            endcase
            h = p / 2;
        end else begin
            case (c)
                0:  begin p = HZ / 4;     h = p / 2;     end
                1:  begin p = HZ;         h = p / 2;     end
                2:  begin p = 4 * HZ;     h = p / 2;     end
                3:  begin p = HZ / 2;     h = p / 2;     end
                4:  begin p = 4 * HZ;     h = p / 4;     end
                5:  begin p = 4 * HZ;     h = 3 * p / 4; end
                6:  begin p = 8 * HZ;     h = p / 4;     end
                7:  begin p = 8 * HZ;     h = 3 * p / 4; end
                8:  begin p = 5 * HZ / 2; h = p / 5;     end
                16: begin p = 2 * HZ;     h = p / 2;     end
                24: begin p = 8 * HZ;     h = p / 2;     end
                default: begin ok = 1'b0; p = HZ; h = 0; end
            endcase
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mdiv <= 0; msync <= 2'b11; mpc <= 0;
            for (int ch = 0; ch < 2; ch++) begin
                mcnt[ch] <= 0; mcode[ch] <= '0; mctrl[ch] <= '0; mmap[ch] <= '0;
            end
        end else begin
            tk = (mdiv == CPT - 1);
            mdiv  <= tk ? 0 : mdiv + 1;
            msync <= {msync[0], sw_n};
            if (msync[1]) mpc <= 0;
            else if (tk && mpc != LONG + 1) mpc <= mpc + 1;
            fire = tk && !msync[1] && (mpc == LONG);
            for (int ch = 0; ch < 2; ch++) begin
                shape(ext, mcode[ch], sok, sp, sh);
                if (wr && addr == {ch[0], 2'd0}) mcnt[ch] <= 0;
                else if (tk) mcnt[ch] <= (mcnt[ch] + 1 >= sp) ? 0 : mcnt[ch] + 1;
                if (fire && ext && mctrl[ch][2]) mmap[ch] <= '0;
                if (wr && addr[2] == ch[0]) begin
                    case (addr[1:0])
                        2'd0: mcode[ch] <= wdata;
                        2'd1: mctrl[ch] <= wdata[2:0];
                        2'd2: mmap[ch]  <= wdata[MW-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic logic chan_lvl(input int ch);
        bit ok; int p, h; logic on;
        shape(ext, mcode[ch], ok, p, h);
        on = ok && (mctrl[ch][0] ? (mcnt[ch] == 0) : (mcnt[ch] < h));
        return on ? ~mctrl[ch][1] : mctrl[ch][1];
    endfunction

    function automatic logic [NP-1:0] exp_led();
        logic [NP-1:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            if (mmap[1] == MW'(p + 1)) v[p] = chan_lvl(1);
            if (mmap[0] == MW'(p + 1)) v[p] = chan_lvl(0);
        end
        return v;
    endfunction

    function automatic logic [4:0] exp_rd();
        int ch = int'(addr[2]);
        case (addr[1:0])
            2'd0: return mcode[ch];
            2'd1: return 5'(mctrl[ch]);
            2'd2: return 5'(mmap[ch]);
            default: return 5'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NP-1:0] el;
            logic [4:0] er;
            el = exp_led();
            er = exp_rd();
            vectors++;
            if (led !== el || rdata !== er) begin
                fails++;
                $display("FAIL %s t=%0t led_o=%b expected %b rdata=%0d expected %0d",
                         cur_req, $time, led, el, rdata, er);
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [4:0] d);
        @(posedge clk); #2; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2; wr = 1'b0; addr = obs;
    endtask

    task automatic look(input logic [2:0] a);
        @(posedge clk); #2; obs = a; addr = a;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic set_sw(input logic v);
        @(posedge clk); #2; sw_n = v;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R12: state while in reset
        repeat (3) @(negedge clk);
        vectors++;
        if (led !== '0 || rdata !== '0) begin
            fails++;
            $display("FAIL R12 led_o=%b rdata=%0d expected 0 0", led, rdata);
        end
        @(posedge clk); #2; rst_n = 1'b1;
        run(6);

        // R1: decode, read-back, channel isolation, unused slot
        cur_req = "R1";
        wr_reg(3'd0, 5'd31); wr_reg(3'd1, 5'd7); wr_reg(3'd2, 5'd31);
        wr_reg(3'd4, 5'd10); wr_reg(3'd5, 5'd2); wr_reg(3'd6, 5'd5);
        for (int a = 0; a < 8; a++) begin look(3'(a)); run(2); end
        wr_reg(3'd4, 5'd0); look(3'd0); run(2); look(3'd2); run(2);

        // R2 R3: narrow table, upper code bits ignored
        cur_req = "R2 R3";
        ext = 1'b0;
        wr_reg(3'd1, 5'd0); wr_reg(3'd5, 5'd0); wr_reg(3'd6, 5'd0); wr_reg(3'd2, 5'd1);
        look(3'd0);
        for (int c = 0; c < 8; c++) begin wr_reg(3'd0, 5'(c * 5)); run(270); end

        // R4 R5 R6: wide table, every code
        ext = 1'b1;
        for (int c = 0; c < 32; c++) begin
            cur_req = (c < 4) ? "R4" : (c < 8) ? "R5" : "R6";
            wr_reg(3'd0, 5'(c)); run(270);
        end

        // R7 R8: short pulse and polarity in both tables
        for (int e = 0; e < 2; e++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 3; s++) begin
                    cur_req = (k[0]) ? "R7" : "R8";
                    ext = e[0];
                    wr_reg(3'd1, 5'(k));
                    wr_reg(3'd0, (s == 0) ? 5'd1 : (s == 1) ? 5'd5 : 5'd8);
                    run(270);
                end

        // R9: routing and priority
        cur_req = "R9";
        ext = 1'b1;
        wr_reg(3'd1, 5'd0); wr_reg(3'd5, 5'd2);
        wr_reg(3'd0, 5'd0); wr_reg(3'd4, 5'd3);
        for (int m0 = 0; m0 < 8; m0++)
            for (int m1 = 0; m1 < 8; m1++) begin
                wr_reg(3'd2, 5'(m0)); wr_reg(3'd6, 5'(m1)); run(20);
            end

        // R11: rewrite of the code mid-period restarts it
        cur_req = "R11";
        wr_reg(3'd2, 5'd1); wr_reg(3'd6, 5'd2);
        wr_reg(3'd0, 5'd24); run(101);
        wr_reg(3'd0, 5'd24); run(53);
        wr_reg(3'd0, 5'd5); run(7);
        wr_reg(3'd4, 5'd16); run(37);
        wr_reg(3'd0, 5'd2); run(150);

        // R10: long press clear
        cur_req = "R10";
        wr_reg(3'd1, 5'd4); wr_reg(3'd5, 5'd0);
        wr_reg(3'd2, 5'd2); wr_reg(3'd6, 5'd3);
        look(3'd2);
        set_sw(1'b0); run(200); set_sw(1'b1); run(10);
        look(3'd6); run(4);
        // short presses do not clear
        wr_reg(3'd2, 5'd2); look(3'd2);
        set_sw(1'b0); run(100); set_sw(1'b1); run(5);
        set_sw(1'b0); run(100); set_sw(1'b1); run(10);
        // narrow table: no clear
        ext = 1'b0;
        set_sw(1'b0); run(200); set_sw(1'b1); run(10);
        // both armed, wide table
        ext = 1'b1;
        wr_reg(3'd5, 5'd4);
        set_sw(1'b0); run(200);
        look(3'd6); run(4);
        set_sw(1'b1); run(10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule